// File: doc/BRIEF.md
# I2C Master Address Byte Transmitter

This block sends the first byte of an I2C master transfer: a 7-bit target address, most significant bit first, followed by a direction bit. It then releases the data line and reads the target's acknowledge. The SDA line is open-drain. The block drives it only by asserting a pull-down enable; a 1 is sent by letting the line float high. SCL itself is produced elsewhere. Single-cycle strobes from an outside edge detector pace the block: one strobe marks an SCL rise, and another marks a slightly delayed SCL fall.

Each transmitted bit is compared with the level sensed on SDA at the SCL rise. When the block releases the line for a 1 and another device holds it low, a contention flag is raised. The result of the acknowledge bit and the end of the byte are reported on two more flags. A surrounding master controller issues one start pulse per address byte. It can run address phases back to back without a reset in between.

Top module: `addr_byte_sender`

## Requirements
- R1: A one-cycle `start_req` taken while `load_en` is high and the block is idle captures `tgt_addr` and `dir_read`, clears `bit_clash`, `no_ack` and `xfer_done`, and arms the transfer. A `start_req` with `load_en` low is ignored.
- R2: The frame is the 7 address bits, most significant first, then the direction bit (1 = read, 0 = write). The n-th delayed-fall strobe after the start places frame bit n on the line.
- R3: `sda_pull` is high only while a 0 bit is being sent. For a 1 bit, while idle, and during the acknowledge bit it is low.
- R4: `sda_pull` changes only in the cycle after a `scl_fall_dly_stb`, so it never changes while SCL is high.
- R5: On each `scl_rise_stb` during the eight frame bits, `bit_clash` becomes 1 if the line was released but `sda_in` reads 0, and becomes 0 otherwise. The value is recomputed at every rise, so it does not carry over to the next bit.
- R6: At the ninth SCL rise, `no_ack` takes the level of `sda_in`: 0 means acknowledged, 1 means not acknowledged. It holds that value until the next accepted start.
- R7: `xfer_done` is low from an accepted start until the delayed fall that ends the acknowledge bit. It then rises and stays high until the next accepted start.
- R8: A second start right after `xfer_done` rises sends a complete, correct second frame with no reset in between.
- R9: A low `rst_n` at a clock edge returns the block to idle, with `sda_pull`, `bit_clash`, `no_ack` and `xfer_done` all 0.
- R10: A `start_req` that arrives while a transfer is in progress has no effect on the bits sent or on the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_req | input | 1 | One-cycle request to send an address byte |
| load_en | input | 1 | Qualifies start_req; captures address and direction |
| tgt_addr | input | ADDR_W | Target address |
| dir_read | input | 1 | Direction bit, 1 = read |
| sda_in | input | 1 | Sensed SDA level |
| scl_rise_stb | input | 1 | One-cycle strobe at an SCL rise |
| scl_fall_dly_stb | input | 1 | One-cycle strobe shortly after an SCL fall |
| sda_pull | output | 1 | Pull-down enable for SDA |
| bit_clash | output | 1 | Released bit sensed low at the last SCL rise |
| no_ack | output | 1 | Acknowledge bit was high |
| xfer_done | output | 1 | Address byte and acknowledge complete |

## Verification
A wrong bit index or a wrong shift register shows up on `sda_pull` at the first delayed-fall strobe after the fault. Because every frame bit is scored in the cycle after its strobe, the error is seen within one SCL period. A phase register stuck in the wrong state shows up as a missing or early `xfer_done`, or as a `no_ack` or `bit_clash` that fails to update at the next rise strobe. All of these are visible within one bit time. A control path that reacts to the wrong strobe shows up as `sda_pull` changing during SCL high. The props checker flags this in the cycle it happens.

// File: rtl/addr_tx_pkg.sv
package addr_tx_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ARM  = 2'd1,
        PH_BITS = 2'd2,
        PH_ACK  = 2'd3
    } phase_e;

    typedef struct packed {
        logic ld;   // capture frame, clear flags
        logic put;  // present next frame bit
        logic rel;  // release line for acknowledge
        logic chk;  // compare sent bit at SCL rise
        logic smp;  // sample acknowledge at SCL rise
        logic fin;  // acknowledge bit ended
    } ctrl_t;

endpackage

// File: rtl/addr_tx_seq.sv
module addr_tx_seq
    import addr_tx_pkg::*;
#(
    parameter int FRAME_W = 8
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  start_req,
    input  logic  load_en,
    input  logic  rise_stb,
    input  logic  fall_stb,
    output ctrl_t ctrl
);
    localparam int CNT_W = (FRAME_W > 1) ? $clog2(FRAME_W) : 1;
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_W - 1);

    typedef struct packed {
        phase_e           phase;
        logic [CNT_W-1:0] idx;
        logic             ack_rise;
    } seq_t;

    seq_t  s_d, s_q;
    ctrl_t c;

    always_comb begin
        s_d = s_q;
        c   = '0;
        unique case (s_q.phase)
            PH_IDLE: begin
                if (start_req && load_en) begin
                    c.ld       = 1'b1;
                    s_d.phase  = PH_ARM;
                    s_d.idx    = '0;
                    s_d.ack_rise = 1'b0;
                end
            end
            PH_ARM: begin
                if (fall_stb) begin
                    c.put     = 1'b1;
                    s_d.phase = PH_BITS;
                    s_d.idx   = '0;
                end
            end
            PH_BITS: begin
                if (rise_stb) begin
                    c.chk = 1'b1;
                end
                if (fall_stb) begin
                    if (s_q.idx == LAST_IDX) begin
                        c.rel        = 1'b1;
                        s_d.phase    = PH_ACK;
                        s_d.ack_rise = 1'b0;
                    end else begin
                        c.put   = 1'b1;
                        s_d.idx = s_q.idx + 1'b1;
                    end
                end
            end
            PH_ACK: begin
                if (rise_stb) begin
                    c.smp        = 1'b1;
                    s_d.ack_rise = 1'b1;
                end
                if (fall_stb && s_q.ack_rise) begin
                    c.fin     = 1'b1;
                    s_d.phase = PH_IDLE;
                end
            end
            default: s_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.phase    <= PH_IDLE;
            s_q.idx      <= '0;
            s_q.ack_rise <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ctrl = c;

endmodule

// File: rtl/addr_tx_shifter.sv
module addr_tx_shifter
    import addr_tx_pkg::*;
#(
    parameter int FRAME_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  ctrl_t              ctrl,
    input  logic [FRAME_W-1:0] frame_in,
    output logic               drive_low
);
    typedef struct packed {
        logic [FRAME_W-1:0] frame;
        logic               drv;
    } shf_t;

    shf_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (ctrl.ld) begin
            r_d.frame = frame_in;
            r_d.drv   = 1'b0;
        end else if (ctrl.put) begin
            r_d.drv   = ~r_q.frame[FRAME_W-1];
            r_d.frame = {r_q.frame[FRAME_W-2:0], 1'b0};
        end else if (ctrl.rel) begin
            r_d.drv   = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.frame <= '0;
            r_q.drv   <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign drive_low = r_q.drv;

endmodule

// File: rtl/addr_tx_flags.sv
module addr_tx_flags
    import addr_tx_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  ctrl_t ctrl,
    input  logic  drive_low,
    input  logic  sda_in,
    output logic  clash,
    output logic  nack,
    output logic  done
);
    typedef struct packed {
        logic clash;
        logic nack;
        logic done;
    } flg_t;

    flg_t f_d, f_q;

    always_comb begin
        f_d = f_q;
        if (ctrl.ld) begin
            f_d = '0;
        end else begin
            if (ctrl.chk) f_d.clash = ~drive_low & ~sda_in;
            if (ctrl.smp) f_d.nack  = sda_in;
            if (ctrl.fin) f_d.done  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            f_q <= '0;
        end else begin
            f_q <= f_d;
        end
    end

    assign clash = f_q.clash;
    assign nack  = f_q.nack;
    assign done  = f_q.done;

endmodule

// File: rtl/addr_byte_sender.sv
module addr_byte_sender
    import addr_tx_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_req,
    input  logic              load_en,
    input  logic [ADDR_W-1:0] tgt_addr,
    input  logic              dir_read,
    input  logic              sda_in,
    input  logic              scl_rise_stb,
    input  logic              scl_fall_dly_stb,
    output logic              sda_pull,
    output logic              bit_clash,
    output logic              no_ack,
    output logic              xfer_done
);
    localparam int FRAME_W = ADDR_W + 1;

    ctrl_t ctrl;
    logic  drv;

    addr_tx_seq #(.FRAME_W(FRAME_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_req(start_req),
        .load_en  (load_en),
        .rise_stb (scl_rise_stb),
        .fall_stb (scl_fall_dly_stb),
        .ctrl     (ctrl)
    );

    addr_tx_shifter #(.FRAME_W(FRAME_W)) u_shf (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl     (ctrl),
        .frame_in ({tgt_addr, dir_read}),
        .drive_low(drv)
    );

    addr_tx_flags u_flg (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl     (ctrl),
        .drive_low(drv),
        .sda_in   (sda_in),
        .clash    (bit_clash),
        .nack     (no_ack),
        .done     (xfer_done)
    );

    assign sda_pull = drv;

endmodule

// File: rtl/addr_byte_sender_props.sv
module addr_byte_sender_props (
    input logic clk,
    input logic rst_n,
    input logic start_req,
    input logic scl_rise_stb,
    input logic scl_fall_dly_stb,
    input logic sda_pull,
    input logic bit_clash,
    input logic no_ack,
    input logic xfer_done
);
    a_r4_pull_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !scl_fall_dly_stb |=> $stable(sda_pull));

    a_r5_clash_moves_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_rise_stb && !start_req) |=> $stable(bit_clash));

    a_r6_nack_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_rise_stb && !start_req) |=> $stable(no_ack));

    a_r7_done_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xfer_done) |-> $past(scl_fall_dly_stb));

    a_r3_released_when_done: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |-> !sda_pull);

    a_r9_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!sda_pull && !bit_clash && !no_ack && !xfer_done));

endmodule

bind addr_byte_sender addr_byte_sender_props u_props (
    .clk             (clk),
    .rst_n           (rst_n),
    .start_req       (start_req),
    .scl_rise_stb    (scl_rise_stb),
    .scl_fall_dly_stb(scl_fall_dly_stb),
    .sda_pull        (sda_pull),
    .bit_clash       (bit_clash),
    .no_ack          (no_ack),
    .xfer_done       (xfer_done)
);

// File: tb/addr_byte_sender_test.sv
module addr_byte_sender_test;
    localparam int CLK_NS = 10;
    localparam int AW     = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_req = 1'b0;
    logic          load_en = 1'b0;
    logic [AW-1:0] tgt_addr = '0;
    logic          dir_read = 1'b0;
    logic          scl_rise_stb = 1'b0;
    logic          scl_fall_dly_stb = 1'b0;
    logic          other_low = 1'b0;
    logic          sda_pull, bit_clash, no_ack, xfer_done;
    logic          sda_in;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    logic exp_q[$];
    string tag_q[$];
    event  slot_ev;

    assign sda_in = !(sda_pull || other_low);

    always #(CLK_NS/2) clk = ~clk;

    addr_byte_sender #(.ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .load_en(load_en),
        .tgt_addr(tgt_addr), .dir_read(dir_read), .sda_in(sda_in),
        .scl_rise_stb(scl_rise_stb), .scl_fall_dly_stb(scl_fall_dly_stb),
        .sda_pull(sda_pull), .bit_clash(bit_clash), .no_ack(no_ack),
        .xfer_done(xfer_done)
    );

    task automatic check(input int act, input int exp, input string tag);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // scoreboard monitor: one expected pull level per bit slot
    initial begin
        forever begin
            @(slot_ev);
            if (exp_q.size() == 0) begin
                check(1, 0, "R2 scoreboard underflow");
            end else begin
                check(int'(sda_pull), int'(exp_q.pop_front()), tag_q.pop_front());
            end
        end
    end

    task automatic fall_pulse();
        @(negedge clk) scl_fall_dly_stb = 1'b1;
        @(negedge clk) scl_fall_dly_stb = 1'b0;
    endtask

    task automatic rise_pulse(input logic hold_low);
        @(negedge clk) begin scl_rise_stb = 1'b1; other_low = hold_low; end
        @(negedge clk) begin scl_rise_stb = 1'b0; other_low = 1'b0; end
    endtask

    task automatic send_start(input logic [AW-1:0] a, input logic rw, input logic en);
        @(negedge clk) begin start_req = 1'b1; load_en = en; tgt_addr = a; dir_read = rw; end
        @(negedge clk) begin start_req = 1'b0; load_en = 1'b0; end
    endtask

    // full address byte; clash_mask bit 7 = first frame bit
    task automatic run_frame(input logic [AW-1:0] a, input logic rw, input logic ack,
                             input logic [7:0] clash_mask, input logic poke_busy);
        logic [7:0] fr;
        logic       pv;
        fr = {a, rw};
        send_start(a, rw, 1'b1);
        check(int'(xfer_done), 0, "R7 done low after start");
        check(int'(sda_pull), 0, "R3 released before first fall");
        for (int k = 7; k >= 0; k--) begin
            exp_q.push_back(!fr[k]);
            tag_q.push_back($sformatf("R2 frame bit %0d", 7 - k));
        end
        fall_pulse();
        -> slot_ev;
        for (int k = 7; k >= 0; k--) begin
            pv = sda_pull;
            rise_pulse(clash_mask[k]);
            check(int'(bit_clash), int'(clash_mask[k] && fr[k]), "R5 clash at rise");
            check(int'(sda_pull), int'(pv), "R4 pull steady over rise");
            if (poke_busy && k == 4) send_start(~a, ~rw, 1'b1); // R10
            if (k == 0) begin
                exp_q.push_back(1'b0);
                tag_q.push_back("R3 released for ack");
            end
            fall_pulse();
            -> slot_ev;
            check(int'(xfer_done), 0, "R7 done low in transfer");
        end
        @(negedge clk) other_low = ack;
        @(negedge clk) scl_rise_stb = 1'b1;
        @(negedge clk) scl_rise_stb = 1'b0;
        check(int'(no_ack), int'(!ack), "R6 ack sample");
        check(int'(xfer_done), 0, "R7 done low before ack fall");
        @(negedge clk) other_low = 1'b0;
        fall_pulse();
        check(int'(xfer_done), 1, "R7 done after ack fall");
        check(int'(no_ack), int'(!ack), "R6 nack held");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(int'(sda_pull), 0, "R9 reset pull");
        check(int'(xfer_done | no_ack | bit_clash), 0, "R9 reset flags");
        @(negedge clk) rst_n = 1'b1;

        // R1: start without load enable is ignored
        send_start(7'h55, 1'b0, 1'b0);
        fall_pulse();
        check(int'(sda_pull), 0, "R1 unqualified start ignored");

        run_frame(7'b1110101, 1'b1, 1'b1, 8'h00, 1'b0);   // read
        run_frame(7'b0001010, 1'b0, 1'b1, 8'h00, 1'b0);   // R8 back to back write
        run_frame(7'b0001010, 1'b0, 1'b0, 8'h00, 1'b0);   // nack
        run_frame(7'b1111111, 1'b0, 1'b1, 8'b10101010, 1'b0); // R5 contention
        run_frame(7'b0110011, 1'b1, 1'b1, 8'h00, 1'b1);   // R10 start while busy

        // R1: start without load_en after done keeps state
        send_start(7'h00, 1'b0, 1'b0);
        check(int'(xfer_done), 1, "R1 unqualified start keeps done");
        fall_pulse();
        check(int'(sda_pull), 0, "R1 no drive after ignored start");

        // R9: reset mid transfer
        send_start(7'h00, 1'b0, 1'b1);
        fall_pulse();
        check(int'(sda_pull), 1, "R2 zero bit driven");
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        check(int'(sda_pull), 0, "R9 pull cleared");
        check(int'(xfer_done | no_ack | bit_clash), 0, "R9 flags cleared");
        fall_pulse();
        check(int'(sda_pull), 0, "R9 idle after reset");

        repeat (2) @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule